// File: doc/BRIEF.md
# Delayed Output Driver with Fault Substitution

This block produces one external output pin from an internal logic level. The level first passes an optional delay line. Polarity inversion is applied to the delayed level. A fault mode then decides what the pin shows while an error flag is active. The pin value is also returned on a monitor output, so that other logic can see exactly what is being driven.

The delay is a base time unit multiplied by a count from 1 to 64, or the delay is bypassed. The base units are counted in clock cycles. With `UNIT_CYC = 1` the clock period is taken as 12.5 ns, and the eight base codes give 12.5 ns up to 1 ms. The delay line stores the due time of each input edge. A pulse shorter than the delay therefore comes out with its width intact. Up to `DEPTH` edges can be waiting at once. An edge that arrives when the store is full is lost, and a sticky overflow flag is set.

The fault modes force the pin low, force it high, or freeze it at the value it had when the error was first seen. When the error clears, the pin follows the delayed, inverted level again.

Top module: `pulse_out_driver`

## Requirements
- R1: After reset `pin_out`, `mon_out` and `ovf` are 0, and no edges are pending.
- R2: With `cfg_dly_en` = 0 and `err_in` = 0, `pin_out` equals `sig_in` XOR `cfg_invert` as sampled one clock edge earlier.
- R3: With `cfg_dly_en` = 1, an input edge sampled at clock edge k appears on `pin_out` at edge k+D+1. D = base(`cfg_base`) × (`cfg_mult`+1) × `UNIT_CYC` cycles, where `cfg_mult` 0..63 encodes the multipliers 1..64.
- R4: Every edge of an input pulse shorter than D is reproduced, so the output pulse keeps its width, provided no more than `DEPTH` edges are pending.
- R5: An edge detected while `DEPTH` edges are pending is dropped, and `ovf` goes to 1 on the next edge. `ovf` stays 1 until reset.
- R6: Inversion is applied to the delayed level, before fault substitution. Forced fault values are not inverted.
- R7: When `err_in` is sampled 1, the pin is updated at that same clock edge. Fault code 2'b00 (and the spare code 2'b11) drives 0, and code 2'b01 drives 1.
- R8: Fault code 2'b10 holds `pin_out` at the value it had when `err_in` was first sampled 1. One edge after `err_in` is sampled 0, the pin follows the delayed level XOR `cfg_invert` again.
- R9: `mon_out` always equals `pin_out`.
- R10: The base codes 0 to 7 select 1, 2, 4, 8, 80, 800, 8000 and 80000 clock cycles, each times `UNIT_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Internal logic level to drive out |
| err_in | input | 1 | Error flag; selects the fault behaviour |
| cfg_invert | input | 1 | 1 inverts the delayed level |
| cfg_dly_en | input | 1 | 1 enables the delay line |
| cfg_base | input | 3 | Base time unit code |
| cfg_mult | input | 6 | Multiplier minus one |
| cfg_fault | input | 2 | Fault mode: 00 low, 01 high, 10 hold, 11 low |
| pin_out | output | 1 | Registered external pin drive |
| mon_out | output | 1 | Copy of the pin drive for internal use |
| ovf | output | 1 | Sticky flag: a pending edge was lost |

## Verification
The assertions check a set of properties on every cycle:
- the forced-low, forced-high and hold fault values;
- the one-cycle bypass path;
- that the pending-edge count stays within bounds;
- that a dropped edge raises `ovf`, and that `ovf` then stays set.

Only the bench scenarios can show the properties that need a whole sequence to be visible:
- the exact delay that each base code and multiplier produces;
- that a short pulse keeps its width;
- that the pin resumes the correct level after a hold ends;
- that a dropped edge leaves the output at the wrong level.

// File: rtl/od_pkg.sv
package od_pkg;

  typedef enum logic [1:0] {
    FLT_LOW  = 2'b00,
    FLT_HIGH = 2'b01,
    FLT_HOLD = 2'b10,
    FLT_SPARE = 2'b11
  } fault_mode_e;

  // Base unit in clock cycles of the 12.5 ns reference tick (R10)
  function automatic int unsigned base_cycles(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      3'd4:    return 80;
      3'd5:    return 800;
      3'd6:    return 8000;
      default: return 80000;
    endcase
  endfunction

  function automatic int unsigned max_delay(input int unsigned unit_cyc);
    return 80000 * unit_cyc * 64;
  endfunction

endpackage

// File: rtl/od_delay_calc.sv
module od_delay_calc #(
  parameter int unsigned UNIT_CYC = 1,
  parameter int unsigned TW = 24
) (
  input  logic [2:0]    cfg_base,
  input  logic [5:0]    cfg_mult,
  output logic [TW-1:0] dly_cyc
);
  import od_pkg::*;

  logic [31:0] prod;

  always_comb begin
    prod    = base_cycles(cfg_base) * UNIT_CYC * (32'(cfg_mult) + 32'd1);
    dly_cyc = prod[TW-1:0];
  end

endmodule

// File: rtl/od_edge_queue.sv
module od_edge_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [TW-1:0] push_due,
  input  logic [TW-1:0] now,
  output logic          pop,
  output logic          full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [TW-1:0] due_mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign full = (count == CW'(DEPTH));
  assign pop  = (count != '0) && (due_mem[rd_ptr] == now);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) due_mem[wr_ptr] <= push_due;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= nxt(wr_ptr);
      if (pop)           rd_ptr <= nxt(rd_ptr);
      case ({push && !full, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R4/R5: pending edges never exceed the store
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R5: a full store accepts nothing, so the count cannot grow
  a_r5_full_no_grow: assert property (@(posedge clk) disable iff (rst)
    full |=> count <= CW'(DEPTH));

endmodule

// File: rtl/od_out_stage.sv
module od_out_stage (
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic       invert,
  input  logic       err,
  input  logic [1:0] mode,
  output logic       pin
);
  import od_pkg::*;

  fault_mode_e fm;
  assign fm = fault_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
    end else if (err) begin
      case (fm)
        FLT_HIGH: pin <= 1'b1;
        FLT_HOLD: pin <= pin;
        default:  pin <= 1'b0;
      endcase
    end else begin
      pin <= lvl ^ invert;
    end
  end

  // R7: forced low for codes 00 and 11
  a_r7_force_low: assert property (@(posedge clk) disable iff (rst)
    err && (mode == 2'b00 || mode == 2'b11) |=> !pin);
  // R7: forced high for code 01
  a_r7_force_high: assert property (@(posedge clk) disable iff (rst)
    err && mode == 2'b01 |=> pin);
  // R8: hold freezes the pin
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    err && mode == 2'b10 |=> $stable(pin));
  // R6: without error the pin is the inverted level
  a_r6_invert: assert property (@(posedge clk) disable iff (rst)
    !err |=> pin == ($past(lvl) ^ $past(invert)));

endmodule

// File: rtl/pulse_out_driver.sv
module pulse_out_driver #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned UNIT_CYC = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sig_in,
  input  logic       err_in,
  input  logic       cfg_invert,
  input  logic       cfg_dly_en,
  input  logic [2:0] cfg_base,
  input  logic [5:0] cfg_mult,
  input  logic [1:0] cfg_fault,
  output logic       pin_out,
  output logic       mon_out,
  output logic       ovf
);
  import od_pkg::*;

  localparam int unsigned MAXD = max_delay(UNIT_CYC);
  localparam int unsigned TW   = $clog2(MAXD + 1) + 1;

  logic [TW-1:0] now, dly_cyc;
  logic          prev_in, dly_lvl, push_req, pop, full, lvl_now;

  od_delay_calc #(.UNIT_CYC(UNIT_CYC), .TW(TW)) u_calc (
    .cfg_base(cfg_base), .cfg_mult(cfg_mult), .dly_cyc(dly_cyc)
  );

  assign push_req = cfg_dly_en && (sig_in != prev_in);

  od_edge_queue #(.DEPTH(DEPTH), .TW(TW)) u_queue (
    .clk(clk), .rst(rst), .push(push_req), .push_due(now + dly_cyc),
    .now(now), .pop(pop), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      now     <= '0;
      prev_in <= 1'b0;
      dly_lvl <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      now     <= now + TW'(1);
      prev_in <= sig_in;
      if (!cfg_dly_en)     dly_lvl <= sig_in;
      else if (pop)        dly_lvl <= ~dly_lvl;
      if (push_req && full) ovf <= 1'b1;
    end
  end

  assign lvl_now = cfg_dly_en ? dly_lvl : sig_in;

  od_out_stage u_out (
    .clk(clk), .rst(rst), .lvl(lvl_now), .invert(cfg_invert),
    .err(err_in), .mode(cfg_fault), .pin(pin_out)
  );

  assign mon_out = pin_out;

  // R5: a lost edge raises the flag
  a_r5_drop_flag: assert property (@(posedge clk) disable iff (rst)
    push_req && full |=> ovf);
  // R5: the flag is sticky
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R2: bypass path has one cycle of latency
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    !cfg_dly_en && !err_in |=> pin_out == ($past(sig_in) ^ $past(cfg_invert)));
  // R9: the monitor copy matches the pin
  a_r9_mirror: assert property (@(posedge clk) disable iff (rst)
    mon_out == pin_out);

endmodule

// File: tb/pulse_out_driver_test.sv
module pulse_out_driver_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic sig_in = 0, err_in = 0, cfg_invert = 0, cfg_dly_en = 0;
  logic [2:0] cfg_base = 0;
  logic [5:0] cfg_mult = 0;
  logic [1:0] cfg_fault = 0;
  logic pin_out, mon_out, ovf;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_out_driver uut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .err_in(err_in),
    .cfg_invert(cfg_invert), .cfg_dly_en(cfg_dly_en), .cfg_base(cfg_base),
    .cfg_mult(cfg_mult), .cfg_fault(cfg_fault), .pin_out(pin_out),
    .mon_out(mon_out), .ovf(ovf)
  );

  // {sig, err, inv, fault[1:0], expected pin one edge later}
  localparam logic [5:0] VEC [14] = '{
    6'b1_0_0_00_1, 6'b0_0_0_00_0, 6'b0_0_1_00_1, 6'b1_0_1_00_0,
    6'b1_0_0_00_1, 6'b1_1_0_00_0, 6'b1_1_0_01_1, 6'b0_1_0_11_0,
    6'b1_1_0_10_0, 6'b0_1_0_10_0, 6'b1_0_0_10_1, 6'b1_1_1_10_1,
    6'b0_0_1_10_1, 6'b0_1_1_00_0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pin(input logic tgt, input int lim, output int n);
    n = 0;
    while (pin_out !== tgt && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic delay_case(input logic [2:0] b, input logic [5:0] m,
                            input int d, input string req);
    int n;
    cfg_base = b; cfg_mult = m;
    @(negedge clk); sig_in = ~sig_in;
    wait_pin(sig_in, d + 50, n);
    chk(req, n, d + 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 pin after reset", pin_out, 0);
    chk("R1 ovf after reset", ovf, 0);
    chk("R1 mon after reset", mon_out, 0);
    rst = 0;

    // R2 R6 R7 R8 R9: bypass vectors
    for (int i = 0; i < 14; i++) begin
      {sig_in, err_in, cfg_invert, cfg_fault} = VEC[i][5:1];
      @(negedge clk);
      chk($sformatf("R2/R6/R7/R8 vec %0d", i), pin_out, VEC[i][0]);
      chk($sformatf("R9 vec %0d", i), mon_out, pin_out);
    end

    err_in = 0; cfg_invert = 0; cfg_fault = 0; sig_in = 0;
    @(negedge clk);
    cfg_dly_en = 1;
    @(negedge clk);

    // R3 R10: latency is D+1 edges after the sampling edge
    delay_case(3'd0, 6'd4, 5, "R3 rise D=5");
    delay_case(3'd0, 6'd4, 5, "R3 fall D=5");
    delay_case(3'd3, 6'd2, 24, "R10 base 8 x3");
    delay_case(3'd4, 6'd0, 80, "R10 base 80 x1");
    delay_case(3'd5, 6'd0, 800, "R10 base 800 x1");
    delay_case(3'd1, 6'd63, 128, "R3 multiplier 64");
    // sig now 0 after an even number of toggles

    // R4: 3-cycle pulse under D=20
    cfg_base = 3'd1; cfg_mult = 6'd9;
    @(negedge clk); sig_in = 1;
    repeat (3) @(negedge clk);
    sig_in = 0;
    wait_pin(1'b1, 100, n);
    chk("R4 pulse rise", n, 19);
    wait_pin(1'b0, 100, n);
    chk("R4 pulse width", n, 3);

    // R5: five edges, four slots
    repeat (5) @(negedge clk);
    chk("R5 ovf clear before burst", ovf, 0);
    for (int k = 0; k < 5; k++) begin
      sig_in = ~sig_in;
      @(negedge clk);
    end
    chk("R5 ovf set", ovf, 1);
    repeat (40) @(negedge clk);
    chk("R5 dropped edge leaves pin low", pin_out, 0);
    chk("R5 input is high", sig_in, 1);
    chk("R5 ovf sticky", ovf, 1);

    rst = 1;
    @(negedge clk);
    chk("R1 ovf cleared by reset", ovf, 0);
    chk("R1 pin cleared by reset", pin_out, 0);
    rst = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule